// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block is a small fetch engine that plays back a list of register writes kept in memory. Software sets an enable bit, loads a start pointer and then writes an end pointer. That last write starts the run. The engine reads 32-bit words one at a time, starting at the start pointer and stopping before the end pointer. It decodes each two-word instruction slot and drives the resulting writes onto a register write port. While the run is in progress a busy flag is high. The flag drops once the final instruction has been applied.

Two write instructions exist. A single write carries one data word, four byte enables and a 20-bit register offset. A burst write carries a count N and then N data words, which all go to the same offset in order. After a burst with an odd count there is one padding word; the engine steps over it without fetching it, so the next instruction starts on an 8-byte boundary. A slot whose opcode is zero does nothing, which lets the zero filler up to a 64-byte aligned end pointer pass through harmlessly. Any other opcode sets a sticky error flag and ends the run.

The engine cannot read registers. Memory is fetched over a one-outstanding request/valid handshake, and each register write is a single-cycle valid pulse carrying address, data and byte enables.

Top module: `cmd_stream_exec`

## Requirements
- R1: A write of the end pointer (config address 2) starts a run when enable is 1, busy is 0 and the new end pointer differs from the start pointer. Busy is 1 from the cycle after that write until the run ends.
- R2: A write of the end pointer while enable is 0, or with a value equal to the start pointer, does not start a run. Busy stays 0 and no fetch is issued.
- R3: A single write has word 0 = data and word 1 = {opcode 8'h01 in bits 31:24, byte enables in bits 23:20, offset in bits 19:0}. It produces exactly one register write with that offset, data and byte enables, and regWrValid is high for exactly one cycle.
- R4: A burst write has word 0 = count N (bits 15:0) and word 1 = {opcode 8'h09 in bits 31:24, offset in bits 19:0}, followed by N data words. It produces N register writes, in stream order, all to that offset, all with byte enables 4'hF.
- R5: After a burst with an odd N, the padding word is skipped without being fetched, and the next instruction is decoded from the next 8-byte boundary.
- R6: A burst with N = 0 produces no register write, and the following instruction still runs.
- R7: A slot whose opcode field is 8'h00 produces no register write.
- R8: Any opcode other than 8'h00, 8'h01 or 8'h09 sets the error flag (control bit 2, also the errFlag port), ends the run with busy cleared, and executes no later instruction. Writing control with bit 2 = 1 while idle clears the flag.
- R9: While busy is 1, writes to the control, start-pointer and end-pointer registers are ignored.
- R10: Fetches go out one at a time. The first fetch is at the start pointer, the addresses then rise by 4, and the number of fetches equals the number of stream words between start and end minus any skipped padding words.
- R11: Config map: address 0 is control (bit 0 enable, read/write; bit 1 busy, read-only; bit 2 error), address 1 is the start pointer and address 2 is the end pointer. Pointer bits 2:0 are held at zero. cfgRdData shows the register selected by cfgAddr.
- R12: Busy drops only after the final register write of a run has been presented, and regWrValid is high only while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Config register write strobe |
| cfgAddr | input | 2 | Config register select (write and read) |
| cfgWrData | input | 32 | Config write data |
| cfgRdData | output | 32 | Config read data for cfgAddr |
| busy | output | 1 | Run in progress |
| errFlag | output | 1 | Sticky unknown-opcode flag |
| memReq | output | 1 | One-cycle fetch request |
| memAddr | output | 16 | Byte address of the fetched word |
| memValid | input | 1 | Fetched word is valid |
| memData | input | 32 | Fetched word |
| regWrValid | output | 1 | Register write valid, one cycle |
| regWrAddr | output | 20 | Register offset |
| regWrData | output | 32 | Register write data |
| regWrBe | output | 4 | Register byte enables |

## Verification
The instruction pointer, the phase register and the burst counter are all internal. When one of them goes wrong it shows up on the ports within one instruction. A bad pointer changes the number of fetches and the first fetch address. A bad phase puts data words into the header fields, so offsets or byte enables come out wrong. A bad counter gives too many or too few writes before the next single write, which then lands out of order. A bad end-of-run decision shows either as busy still high after the last write or as a write appearing after busy has fallen. Both are visible in the cycle the run should end.

// File: rtl/cse_pkg.sv
package cse_pkg;
  // instruction word layout (fixed by the stream format)
  localparam int OFF_W = 20;
  localparam logic [7:0] OP_NOP     = 8'h00;
  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  // config register select
  localparam logic [1:0] CSR_CTRL = 2'd0;
  localparam logic [1:0] CSR_HEAD = 2'd1;
  localparam logic [1:0] CSR_TAIL = 2'd2;

  typedef enum logic [1:0] {PH_W0, PH_W1, PH_DATA} phaseT;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_DECODE, S_NEXT} stateT;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic ldPtr;
    logic advPtr;
    logic alignPtr;
    logic ldW0;
    logic ldW1;
    logic ldCount;
    logic emitData;
    logic emitDirect;
    logic setErr;
  } ctlStrobeT;
endpackage

// File: rtl/cse_control.sv
module cse_control
  import cse_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      kick,
  input  logic      memValid,
  input  logic [7:0] opcode,
  input  logic      countZero,
  input  logic      lastData,
  input  logic      atEnd,
  output ctlStrobeT stb,
  output logic      busy,
  output logic      memReq
);
  stateT state, stateNext;
  phaseT phase, phaseNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    phaseNext = phase;
    case (state)
      S_IDLE: begin
        if (kick) begin
          stb.ldPtr = 1'b1;
          phaseNext = PH_W0;
          stateNext = S_REQ;
        end
      end
      S_REQ: stateNext = S_WAIT;
      S_WAIT: begin
        if (memValid) begin
          stb.advPtr = 1'b1;
          case (phase)
            PH_W0: begin
              stb.ldW0  = 1'b1;
              phaseNext = PH_W1;
              stateNext = S_REQ;
            end
            PH_W1: begin
              stb.ldW1  = 1'b1;
              stateNext = S_DECODE;
            end
            default: begin
              stb.emitData = 1'b1;
              if (lastData) begin
                stb.alignPtr = 1'b1;
                stateNext    = S_NEXT;
              end else begin
                stateNext = S_REQ;
              end
            end
          endcase
        end
      end
      S_DECODE: begin
        case (opcode)
          OP_NOP: stateNext = S_NEXT;
          OP_DIRECT: begin
            stb.emitDirect = 1'b1;
            stateNext      = S_NEXT;
          end
          OP_INDEXED: begin
            stb.ldCount = 1'b1;
            if (countZero) begin
              stateNext = S_NEXT;
            end else begin
              phaseNext = PH_DATA;
              stateNext = S_REQ;
            end
          end
          default: begin
            stb.setErr = 1'b1;
            stateNext  = S_IDLE;
          end
        endcase
      end
      S_NEXT: begin
        if (atEnd) begin
          stateNext = S_IDLE;
        end else begin
          phaseNext = PH_W0;
          stateNext = S_REQ;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= PH_W0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  assign busy   = (state != S_IDLE);
  assign memReq = (state == S_REQ);

  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kick && !busy) |=> busy);
endmodule

// File: rtl/cse_datapath.sv
module cse_datapath
  import cse_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      cfgRdData,
  input  logic             busyIn,
  input  ctlStrobeT        stb,
  input  logic [31:0]      memData,
  output logic [AW-1:0]    memAddr,
  output logic             regWrValid,
  output logic [OFF_W-1:0] regWrAddr,
  output logic [31:0]      regWrData,
  output logic [3:0]       regWrBe,
  output logic             kick,
  output logic [7:0]       opcode,
  output logic             countZero,
  output logic             lastData,
  output logic             atEnd,
  output logic             errFlag
);
  localparam int PAD_W = 32 - AW;
  localparam logic [AW-1:0] WORD_B = AW'(4);

  logic          enableReg, errReg;
  logic [AW-1:0] headReg, tailReg, ptr;
  logic [31:0]   w0, w1;
  logic [CW-1:0] count;
  logic [AW-1:0] ptrInc, ptrNext, cfgPtr;
  logic          wrCtrl, wrHead, wrTail;
  logic          unusedCfg;

  assign cfgPtr    = {cfgWrData[AW-1:3], 3'b000};
  assign unusedCfg = ^{cfgWrData[31:AW], cfgWrData[2:0], cfgWrData[1]};

  assign wrCtrl = cfgWrEn && (cfgAddr == CSR_CTRL) && !busyIn;
  assign wrHead = cfgWrEn && (cfgAddr == CSR_HEAD) && !busyIn;
  assign wrTail = cfgWrEn && (cfgAddr == CSR_TAIL) && !busyIn;
  assign kick   = wrTail && enableReg && (cfgPtr != headReg);

  // pointer advance, with skip of the padding word after an odd burst
  assign ptrInc  = ptr + WORD_B;
  assign ptrNext = (stb.alignPtr && ptrInc[2]) ? ptrInc + WORD_B : ptrInc;

  assign opcode    = w1[31:24];
  assign countZero = (w0[CW-1:0] == '0);
  assign lastData  = (count == CW'(1));
  assign atEnd     = (ptr >= tailReg);
  assign memAddr   = ptr;
  assign errFlag   = errReg;

  always_comb begin
    case (cfgAddr)
      CSR_CTRL: cfgRdData = {29'd0, errReg, busyIn, enableReg};
      CSR_HEAD: cfgRdData = {{PAD_W{1'b0}}, headReg};
      CSR_TAIL: cfgRdData = {{PAD_W{1'b0}}, tailReg};
      default:  cfgRdData = 32'd0;
    endcase
  end

  // config and status registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      errReg    <= 1'b0;
      headReg   <= '0;
      tailReg   <= '0;
    end else begin
      if (wrCtrl) begin
        enableReg <= cfgWrData[0];
        if (cfgWrData[2]) errReg <= 1'b0;
      end
      if (stb.setErr) errReg <= 1'b1;
      if (wrHead) headReg <= cfgPtr;
      if (wrTail) tailReg <= cfgPtr;
    end
  end

  // fetch pointer, instruction words and burst counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr   <= '0;
      w0    <= '0;
      w1    <= '0;
      count <= '0;
    end else begin
      if (stb.ldPtr) ptr <= headReg;
      else if (stb.advPtr) ptr <= ptrNext;
      if (stb.ldW0) w0 <= memData;
      if (stb.ldW1) w1 <= memData;
      if (stb.ldCount) count <= w0[CW-1:0];
      else if (stb.emitData) count <= count - CW'(1);
    end
  end

  // register write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrValid <= 1'b0;
      regWrAddr  <= '0;
      regWrData  <= '0;
      regWrBe    <= '0;
    end else begin
      regWrValid <= stb.emitDirect || stb.emitData;
      if (stb.emitDirect) begin
        regWrAddr <= w1[OFF_W-1:0];
        regWrData <= w0;
        regWrBe   <= w1[23:20];
      end else if (stb.emitData) begin
        regWrAddr <= w1[OFF_W-1:0];
        regWrData <= memData;
        regWrBe   <= 4'hF;
      end
    end
  end

  // R12
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid |-> busyIn);
  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid |=> !regWrValid);
  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> ($stable(headReg) && $stable(tailReg)));
  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |-> enableReg);
  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errReg) |-> !busyIn);
endmodule

// File: rtl/cmd_stream_exec.sv
module cmd_stream_exec
  import cse_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      cfgRdData,
  output logic             busy,
  output logic             errFlag,
  output logic             memReq,
  output logic [AW-1:0]    memAddr,
  input  logic             memValid,
  input  logic [31:0]      memData,
  output logic             regWrValid,
  output logic [OFF_W-1:0] regWrAddr,
  output logic [31:0]      regWrData,
  output logic [3:0]       regWrBe
);
  ctlStrobeT  stb;
  logic       kick, countZero, lastData, atEnd;
  logic [7:0] opcode;

  cse_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .kick      (kick),
    .memValid  (memValid),
    .opcode    (opcode),
    .countZero (countZero),
    .lastData  (lastData),
    .atEnd     (atEnd),
    .stb       (stb),
    .busy      (busy),
    .memReq    (memReq)
  );

  cse_datapath #(.AW(AW), .CW(CW)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgWrData  (cfgWrData),
    .cfgRdData  (cfgRdData),
    .busyIn     (busy),
    .stb        (stb),
    .memData    (memData),
    .memAddr    (memAddr),
    .regWrValid (regWrValid),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .regWrBe    (regWrBe),
    .kick       (kick),
    .opcode     (opcode),
    .countZero  (countZero),
    .lastData   (lastData),
    .atEnd      (atEnd),
    .errFlag    (errFlag)
  );
endmodule

// File: tb/test_cmd_stream_exec.sv
`timescale 1ns/1ps
module test_cmd_stream_exec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [31:0] cfgWrData = 32'd0;
  logic [31:0] cfgRdData;
  logic        busy, errFlag, memReq, memValid, regWrValid;
  logic [15:0] memAddr;
  logic [31:0] memData, regWrData;
  logic [19:0] regWrAddr;
  logic [3:0]  regWrBe;

  int nChecks = 0;
  int nErrors = 0;

  always #2 clk = ~clk;

  cmd_stream_exec i_cmd_stream_exec (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .busy(busy),
    .errFlag(errFlag), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .regWrValid(regWrValid),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regWrBe(regWrBe)
  );

  // memory model: 64 words, two-cycle response latency
  logic [31:0] mem [0:63];
  logic        pend;
  logic [5:0]  pIdx;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend     <= 1'b0;
      memValid <= 1'b0;
      memData  <= 32'd0;
      pIdx     <= 6'd0;
    end else begin
      pend     <= memReq;
      pIdx     <= memAddr[7:2];
      memValid <= pend;
      memData  <= mem[pIdx];
    end
  end

  // observers, sampled on the falling edge
  logic [19:0] logAddr [0:255];
  logic [31:0] logData [0:255];
  logic [3:0]  logBe   [0:255];
  int          logN = 0;
  int          reqN = 0;
  logic [15:0] reqAddr [0:255];
  always @(negedge clk) begin
    if (rstN && regWrValid && logN < 256) begin
      logAddr[logN] = regWrAddr;
      logData[logN] = regWrData;
      logBe[logN]   = regWrBe;
      logN++;
    end
    if (rstN && memReq && reqN < 256) begin
      reqAddr[reqN] = memAddr;
      reqN++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (busy) begin
      nChecks++; nErrors++;
      $display("FAIL %s: actual busy=1 expected busy=0 (run did not end)", tag);
    end
  endtask

  task automatic putDirect(input int idx, input logic [19:0] off, input logic [31:0] d, input logic [3:0] be);
    mem[idx]   = d;
    mem[idx+1] = {8'h01, be, off};
  endtask

  task automatic putBurst(input int idx, input logic [19:0] off, input logic [31:0] n);
    mem[idx]   = n;
    mem[idx+1] = {8'h09, 4'h0, off};
  endtask

  task automatic runStream(input logic [31:0] head, input logic [31:0] tail, input string tag,
                           output int logBase, output int reqBase);
    cfgWrite(2'd1, head);
    logBase = logN;
    reqBase = reqN;
    cfgWrite(2'd2, tail);
    chk({tag, " R1 busy after end-pointer write"}, {31'd0, busy}, 32'd1);
    waitIdle(tag);
  endtask

  task automatic testReset();
    logic [31:0] r;
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset regWrValid", {31'd0, regWrValid}, 32'd0);
    cfgRead(2'd0, r);
    chk("R11 reset control", r, 32'd0);
  endtask

  task automatic testDirect();
    int lb, rb;
    runStream(32'd0, 32'd64, "direct", lb, rb);
    chk("R3 write count", logN - lb, 2);
    chk("R3 first offset", {12'd0, logAddr[lb]}, 32'h12345);
    chk("R3 first data", logData[lb], 32'hA5A5_0001);
    chk("R3 first be", {28'd0, logBe[lb]}, 32'hF);
    chk("R3 second offset", {12'd0, logAddr[lb+1]}, 32'h00040);
    chk("R3 second data", logData[lb+1], 32'hDEAD_BEEF);
    chk("R3 second be", {28'd0, logBe[lb+1]}, 32'h3);
    chk("R7 filler fetched, no extra write; fetch count R10", reqN - rb, 16);
    chk("R10 first fetch at start pointer", {16'd0, reqAddr[rb]}, 32'd0);
    chk("R10 last fetch below end pointer", {16'd0, reqAddr[rb+15]}, 32'd60);
  endtask

  task automatic testOddBurst();
    int lb, rb;
    runStream(32'd64, 32'd128, "odd", lb, rb);
    chk("R4 R5 write count", logN - lb, 4);
    for (int i = 0; i < 3; i++) begin
      chk("R4 burst offset", {12'd0, logAddr[lb+i]}, 32'h00100);
      chk("R4 burst data order", logData[lb+i], 32'hB000_0000 + i);
      chk("R4 burst be", {28'd0, logBe[lb+i]}, 32'hF);
    end
    chk("R5 next instruction offset", {12'd0, logAddr[lb+3]}, 32'h00200);
    chk("R5 next instruction data", logData[lb+3], 32'h55);
    chk("R5 next instruction be", {28'd0, logBe[lb+3]}, 32'hC);
    chk("R5 R10 padding not fetched", reqN - rb, 15);
  endtask

  task automatic testEvenAndEmpty();
    int lb, rb;
    runStream(32'd128, 32'd192, "even", lb, rb);
    chk("R6 write count", logN - lb, 3);
    chk("R4 even burst data 0", logData[lb], 32'hC000_0000);
    chk("R4 even burst data 1", logData[lb+1], 32'hC000_0001);
    chk("R6 write after empty burst offset", {12'd0, logAddr[lb+2]}, 32'h00500);
    chk("R6 write after empty burst data", logData[lb+2], 32'h77);
  endtask

  task automatic testError();
    int lb, rb;
    logic [31:0] r;
    runStream(32'd192, 32'd256, "error", lb, rb);
    chk("R8 only writes before bad opcode", logN - lb, 1);
    chk("R8 write before bad opcode", logData[lb], 32'h11);
    chk("R8 error flag", {31'd0, errFlag}, 32'd1);
    cfgRead(2'd0, r);
    chk("R8 R11 control reads error, enabled, idle", r, 32'h5);
    cfgWrite(2'd0, 32'h5);
    cfgRead(2'd0, r);
    chk("R8 error cleared", r, 32'h1);
  endtask

  task automatic testNoStart();
    int lb, rb;
    cfgWrite(2'd0, 32'h0);
    cfgWrite(2'd1, 32'd0);
    lb = logN; rb = reqN;
    cfgWrite(2'd2, 32'd64);
    chk("R2 disabled: busy", {31'd0, busy}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R2 disabled: no fetch", reqN - rb, 0);
    cfgWrite(2'd0, 32'h1);
    cfgWrite(2'd1, 32'd64);
    cfgWrite(2'd2, 32'd64);
    chk("R2 equal pointers: busy", {31'd0, busy}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R2 equal pointers: no fetch or write", (reqN - rb) + (logN - lb), 0);
  endtask

  task automatic testBusyIgnore();
    int lb;
    logic [31:0] r;
    cfgWrite(2'd1, 32'd0);
    lb = logN;
    cfgWrite(2'd2, 32'd64);
    cfgWrite(2'd2, 32'd0);
    cfgWrite(2'd1, 32'd128);
    cfgWrite(2'd0, 32'd0);
    cfgRead(2'd2, r);
    chk("R9 end pointer held", r, 32'd64);
    cfgRead(2'd1, r);
    chk("R9 start pointer held", r, 32'd0);
    cfgRead(2'd0, r);
    chk("R9 R11 control enabled and busy", r, 32'h3);
    waitIdle("busy-ignore");
    chk("R9 R12 run completed with both writes", logN - lb, 2);
    chk("R12 busy low after last write", {31'd0, busy}, 32'd0);
  endtask

  task automatic testPtrLowBits();
    logic [31:0] r;
    cfgWrite(2'd1, 32'h47);
    cfgRead(2'd1, r);
    chk("R11 start pointer low bits zero", r, 32'h40);
  endtask

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    putDirect(0, 20'h12345, 32'hA5A5_0001, 4'hF);
    putDirect(2, 20'h00040, 32'hDEAD_BEEF, 4'h3);
    putBurst(16, 20'h00100, 32'd3);
    mem[18] = 32'hB000_0000; mem[19] = 32'hB000_0001; mem[20] = 32'hB000_0002;
    mem[21] = 32'hFFFF_FFFF;
    putDirect(22, 20'h00200, 32'h55, 4'hC);
    putBurst(32, 20'h00300, 32'd2);
    mem[34] = 32'hC000_0000; mem[35] = 32'hC000_0001;
    putBurst(36, 20'h00400, 32'd0);
    putDirect(38, 20'h00500, 32'h77, 4'h1);
    putDirect(48, 20'h00600, 32'h11, 4'hF);
    mem[50] = 32'd0; mem[51] = {8'h05, 24'h000700};
    putDirect(52, 20'h00700, 32'h22, 4'hF);

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    cfgWrite(2'd0, 32'h1);
    testDirect();
    testOddBurst();
    testEvenAndEmpty();
    testError();
    testNoStart();
    testBusyIgnore();
    testPtrLowBits();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule